// File: doc/BRIEF.md
# Polled Byte-Wide Serial Port

This block is a serial port that sits on a processor's memory bus and is driven entirely by polling. Four byte-wide locations are picked by two address bits. The port answers only while both of its selects are active: one select is active-high and the other is active-low.

- **Data location.** Reading it returns the last received character. Writing it queues a character for sending.
- **Status location.** Reading it gives the receive, transmit and error flags. Writing it, with any value, is a soft reset.
- **Command and control locations.** Both are read/write. The control byte sets the bit rate, the word length and the stop-bit count.

Bit timing comes from a separate 1.8432 MHz reference input. That input is sampled in the bus clock domain, so the bus clock must run at several times the reference rate. Each rising edge of the reference counts toward a 16x oversampling tick. A fixed 16-entry table of divisors sets how many reference edges make one tick.

A typical setup writes 0x0B to command and 0x1F to control. This gives 8 data bits, no parity, one stop bit at 19200 baud, with interrupts off. Software then polls the receive-full flag and reads the data location.

Top module: `sercon_port`

## Requirements
- R1: After reset the transmit line is high, status reads 0x10, and command and control both read 0x00.
- R2: A read or write takes effect only when `cs_hi`=1 and `cs_n`=0. A write without both selects changes no register. A read without both selects leaves `rdata` unchanged. A selected read presents its value on `rdata` one clock after the read strobe.
- R3: Writing offset 0 sends the byte as one frame: a low start bit, then the data bits least significant bit first, then a high stop bit. Each bit lasts 16 oversampling ticks.
- R4: Status bit 4 (transmit empty) is 0 while a written byte waits for the transmitter. It returns to 1 once the transmitter has taken that byte.
- R5: With control bit 4 = 1, one tick is D rising edges of the reference, where D is selected by control[3:0]:
  - 0→1, 1→2304, 2→1536, 3→1048, 4→856, 5→768, 6→384, 7→192
  - 8→96, 9→64, 10→48, 11→32, 12→24, 13→16, 14→12, 15→6

  With control bit 4 = 0, D = 1.
- R6: Control[6:5] sets the word length for both directions: 00=8, 01=7, 10=6, 11=5 bits. A received short word is right-aligned, and its unused upper bits read 0.
- R7: With control bit 7 = 1, the transmitter sends two stop bits. With control bit 7 = 0, it sends one.
- R8: When a frame completes, status bit 3 becomes 1 and offset 0 returns the byte. A selected read of offset 0 clears bits 3, 2 and 1.
- R9: The receiver re-checks the start bit at mid-bit. A low pulse shorter than half a bit yields no byte.
- R10: A received frame whose stop bit is low sets status bit 1 (framing error) and still delivers its byte.
- R11: A frame that completes while status bit 3 is already 1 sets status bit 2 (overrun) and keeps the earlier byte.
- R12: A selected write to offset 1 clears status bits 1, 2 and 3, and returns command and control to 0x00.
- R13: Command reads back the last value written to it. Status bit 7 (interrupt pending) and bit 0 (parity error) always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | 1.8432 MHz bit-timing reference |
| cs_hi | input | 1 | Active-high chip select |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 2 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line |

## Verification
A wrong divisor or tick count moves every bit edge on `txd`. A mid-bit decode at the expected rate therefore fails within the first one or two data bits of a frame. A flag update that is stuck or misordered appears in the very next status read after a frame completes. An overrun that overwrites the held byte shows up as the wrong value on the following data read. A soft reset that misses a register shows up as a non-zero command or control read-back one clock later.

// File: rtl/sercon_pkg.sv
package sercon_pkg;

  localparam int DIV_W = 12;

  typedef enum logic [1:0] {LN_IDLE, LN_START, LN_DATA, LN_STOP} line_state_t;

  // Reference edges per 16x tick, chosen by the 4-bit rate field.
  function automatic logic [DIV_W-1:0] baud_divisor(input logic [3:0] sel);
    logic [DIV_W-1:0] d;
    case (sel)
      4'd0:  d = DIV_W'(1);
      4'd1:  d = DIV_W'(2304);
      4'd2:  d = DIV_W'(1536);
      4'd3:  d = DIV_W'(1048);
      4'd4:  d = DIV_W'(856);
      4'd5:  d = DIV_W'(768);
      4'd6:  d = DIV_W'(384);
      4'd7:  d = DIV_W'(192);
      4'd8:  d = DIV_W'(96);
      4'd9:  d = DIV_W'(64);
      4'd10: d = DIV_W'(48);
      4'd11: d = DIV_W'(32);
      4'd12: d = DIV_W'(24);
      4'd13: d = DIV_W'(16);
      4'd14: d = DIV_W'(12);
      default: d = DIV_W'(6);
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sercon_refdiv.sv
module sercon_refdiv #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_clk,
  input  logic [DW-1:0] divisor,
  output logic          tick
);
  logic [2:0]    ref_sh;
  logic [DW-1:0] cnt;
  logic          ref_rise;

  assign ref_rise = ref_sh[1] & ~ref_sh[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sh <= '0;
      cnt    <= '0;
      tick   <= 1'b0;
    end else begin
      ref_sh <= {ref_sh[1:0], ref_clk};
      tick   <= 1'b0;
      if (ref_rise) begin
        if (cnt >= divisor - 1'b1) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sercon_tx.sv
module sercon_tx
  import sercon_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16,
  localparam int CW = $clog2(DW + 1),
  localparam int SW = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load_ok,
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] nbits,
  input  logic          two_stop,
  output logic          take,
  output logic          line
);
  line_state_t   st;
  logic [SW-1:0] sub;
  logic [CW-1:0] bitn;
  logic [DW-1:0] sh;
  logic          stop2;

  assign take = (st == LN_IDLE) && load_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= LN_IDLE;
      sub   <= '0;
      bitn  <= '0;
      sh    <= '0;
      stop2 <= 1'b0;
      line  <= 1'b1;
    end else if (take) begin
      st    <= LN_START;
      sh    <= din;
      sub   <= '0;
      stop2 <= 1'b0;
      line  <= 1'b0;
    end else if (tick && st != LN_IDLE) begin
      if (sub != SW'(OVS - 1)) begin
        sub <= sub + 1'b1;
      end else begin
        sub <= '0;
        case (st)
          LN_START: begin
            line <= sh[0];
            sh   <= sh >> 1;
            bitn <= CW'(1);
            st   <= LN_DATA;
          end
          LN_DATA: begin
            if (bitn == nbits) begin
              line <= 1'b1;
              st   <= LN_STOP;
            end else begin
              line <= sh[0];
              sh   <= sh >> 1;
              bitn <= bitn + 1'b1;
            end
          end
          LN_STOP: begin
            if (two_stop && !stop2) stop2 <= 1'b1;
            else st <= LN_IDLE;
          end
          default: st <= LN_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sercon_rx.sv
module sercon_rx
  import sercon_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16,
  localparam int CW = $clog2(DW + 1),
  localparam int SW = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic [CW-1:0] nbits,
  output logic          done,
  output logic [DW-1:0] byte_o,
  output logic          bad_o
);
  localparam logic [SW-1:0] HALF = SW'(OVS / 2 - 1);
  localparam logic [SW-1:0] LAST = SW'(OVS - 1);
  localparam logic [CW-1:0] DWC  = CW'(DW);

  line_state_t   st;
  logic [1:0]    sync;
  logic [SW-1:0] sub;
  logic [CW-1:0] bitn;
  logic [DW-1:0] sh;
  logic          rx_s;

  assign rx_s = sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= LN_IDLE;
      sync   <= 2'b11;
      sub    <= '0;
      bitn   <= '0;
      sh     <= '0;
      done   <= 1'b0;
      byte_o <= '0;
      bad_o  <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      done <= 1'b0;
      if (tick) begin
        case (st)
          LN_IDLE: begin
            sub <= '0;
            if (!rx_s) st <= LN_START;
          end
          LN_START: begin
            if (sub == HALF) begin
              sub  <= '0;
              bitn <= '0;
              st   <= rx_s ? LN_IDLE : LN_DATA;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          LN_DATA: begin
            if (sub == LAST) begin
              sub  <= '0;
              sh   <= {rx_s, sh[DW-1:1]};
              bitn <= bitn + 1'b1;
              if (bitn == nbits - 1'b1) st <= LN_STOP;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          default: begin
            if (sub == LAST) begin
              done   <= 1'b1;
              bad_o  <= ~rx_s;
              byte_o <= sh >> (DWC - nbits);
              sub    <= '0;
              st     <= LN_IDLE;
            end else begin
              sub <= sub + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sercon_port.sv
module sercon_port
  import sercon_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16,
  parameter int AW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_clk,
  input  logic          cs_hi,
  input  logic          cs_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          txd,
  input  logic          rxd
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [AW-1:0] OFS_DATA = AW'(0);
  localparam logic [AW-1:0] OFS_STAT = AW'(1);
  localparam logic [AW-1:0] OFS_CMD  = AW'(2);
  localparam logic [AW-1:0] OFS_CTRL = AW'(3);

  logic [DW-1:0]    cmd_q, ctrl_q, hold_q, rx_data;
  logic             hold_full, rx_full, ovr_q, frm_q;
  logic             sel, wr_hit, rd_hit, rd_data_hit, soft_rst;
  logic             tick, take, rx_done, rx_bad;
  logic [DW-1:0]    rx_byte, status;
  logic [DIV_W-1:0] divisor;
  logic [CW-1:0]    nbits;

  assign sel         = cs_hi & ~cs_n;
  assign wr_hit      = sel & wr_en;
  assign rd_hit      = sel & rd_en;
  assign rd_data_hit = rd_hit && addr == OFS_DATA;
  assign soft_rst    = wr_hit && addr == OFS_STAT;
  assign divisor     = ctrl_q[4] ? baud_divisor(ctrl_q[3:0]) : DIV_W'(1);
  assign nbits       = CW'(DW) - CW'(ctrl_q[6:5]);
  assign status      = DW'({3'b000, ~hold_full, rx_full, ovr_q, frm_q, 1'b0});

  sercon_refdiv #(.DW(DIV_W)) u_div (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .divisor(divisor), .tick(tick)
  );

  sercon_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .load_ok(hold_full), .din(hold_q),
    .nbits(nbits), .two_stop(ctrl_q[7]), .take(take), .line(txd)
  );

  sercon_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .nbits(nbits),
    .done(rx_done), .byte_o(rx_byte), .bad_o(rx_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      ctrl_q    <= '0;
      hold_q    <= '0;
      hold_full <= 1'b0;
      rx_data   <= '0;
      rx_full   <= 1'b0;
      ovr_q     <= 1'b0;
      frm_q     <= 1'b0;
      rdata     <= '0;
    end else begin
      if (take) hold_full <= 1'b0;
      if (wr_hit && addr == OFS_DATA) begin
        hold_q    <= wdata;
        hold_full <= 1'b1;
      end
      if (rd_hit) begin
        case (addr)
          OFS_DATA: rdata <= rx_data;
          OFS_STAT: rdata <= status;
          OFS_CMD:  rdata <= cmd_q;
          default:  rdata <= ctrl_q;
        endcase
      end
      if (rd_data_hit) begin
        rx_full <= 1'b0;
        ovr_q   <= 1'b0;
        frm_q   <= 1'b0;
      end
      if (rx_done) begin
        if (rx_full && !rd_data_hit) begin
          ovr_q <= 1'b1;
        end else begin
          rx_data <= rx_byte;
          rx_full <= 1'b1;
          frm_q   <= rx_bad;
        end
      end
      if (wr_hit && addr == OFS_CMD)  cmd_q  <= wdata;
      if (wr_hit && addr == OFS_CTRL) ctrl_q <= wdata;
      if (soft_rst) begin
        cmd_q   <= '0;
        ctrl_q  <= '0;
        rx_full <= 1'b0;
        ovr_q   <= 1'b0;
        frm_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sercon_port_chk.sv
module sercon_port_chk #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_hi,
  input logic          cs_n,
  input logic [AW-1:0] addr,
  input logic          rd_en,
  input logic          wr_en,
  input logic          rx_done,
  input logic          rx_full,
  input logic          ovr_q,
  input logic          frm_q,
  input logic          hold_full,
  input logic [DW-1:0] rx_data,
  input logic [DW-1:0] cmd_q,
  input logic [DW-1:0] ctrl_q
);
  logic sel;
  assign sel = cs_hi & ~cs_n;

  assert_deselect_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(cmd_q) && $stable(ctrl_q));

  assert_queue_clears_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en && addr == AW'(0)) |=> hold_full);

  assert_read_clears_full_R8: assert property (@(posedge clk) disable iff (rst)
    (sel && rd_en && addr == AW'(0) && !rx_done) |=> !rx_full && !ovr_q && !frm_q);

  assert_overrun_keeps_byte_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_full && !(sel && rd_en && addr == AW'(0)) && !(sel && wr_en && addr == AW'(1)))
    |=> ovr_q && $stable(rx_data));

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en && addr == AW'(1)) |=> cmd_q == '0 && ctrl_q == '0 && !rx_full && !ovr_q);
endmodule

bind sercon_port sercon_port_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cs_hi(cs_hi), .cs_n(cs_n), .addr(addr), .rd_en(rd_en),
  .wr_en(wr_en), .rx_done(rx_done), .rx_full(rx_full), .ovr_q(ovr_q), .frm_q(frm_q),
  .hold_full(hold_full), .rx_data(rx_data), .cmd_q(cmd_q), .ctrl_q(ctrl_q)
);

// File: tb/sercon_port_test.sv
`timescale 1ns/1ps
module sercon_port_test;
  logic       clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_hi = 1'b0;
  logic       cs_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       txd;
  logic       rxd = 1'b1;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;
  always #10 ref_clk = ~ref_clk;   // four bus clocks per reference cycle

  sercon_port uut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .cs_hi(cs_hi), .cs_n(cs_n),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .txd(txd), .rxd(rxd)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d,
                        input logic h = 1'b1, input logic n = 1'b0);
    @(negedge clk);
    cs_hi = h; cs_n = n; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cs_hi = 1'b0; cs_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d,
                        input logic h = 1'b1, input logic n = 1'b0);
    @(negedge clk);
    cs_hi = h; cs_n = n; addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; cs_hi = 1'b0; cs_n = 1'b1;
    d = rdata;
  endtask

  // Bit time in bus clocks: 16 ticks x divisor reference edges x 4 clocks.
  function automatic int bit_cyc(input int div);
    return 16 * div * 4;
  endfunction

  task automatic check_tx(input string req, input logic [7:0] exp, input int n, input int bc);
    int w = 0;
    logic [7:0] got = 8'h00;
    while (txd !== 1'b0 && w < 60000) begin
      @(negedge clk);
      w++;
    end
    repeat (bc / 2) @(negedge clk);
    chk({req, " start"}, {7'b0, txd}, 8'h00);
    for (int i = 0; i < n; i++) begin
      repeat (bc) @(negedge clk);
      got[i] = txd;
    end
    chk({req, " data"}, got, exp & 8'((1 << n) - 1));
    repeat (bc) @(negedge clk);
    chk({req, " stop"}, {7'b0, txd}, 8'h01);
  endtask

  task automatic send_rx(input logic [7:0] v, input int n, input int bc, input logic stop_ok);
    rxd = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = v[i];
      repeat (bc) @(negedge clk);
    end
    rxd = stop_ok;
    repeat (bc * 3 / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (bc / 4) @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] prev;
    logic [7:0] v;
    int bc;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 txd idle", {7'b0, txd}, 8'h01);
    bus_rd(2'd1, r); chk("R1 status", r, 8'h10);
    bus_rd(2'd2, r); chk("R1 command", r, 8'h00);
    bus_rd(2'd3, r); chk("R1 control", r, 8'h00);

    // R13 command read-back, polled status bits 7 and 0 stay low
    bus_wr(2'd2, 8'h0B);
    bus_rd(2'd2, r); chk("R13 command", r, 8'h0B);
    bus_rd(2'd1, r); chk("R13 status", r, 8'h10);

    // R2 chip-select qualification
    bus_wr(2'd3, 8'h1F);
    bus_wr(2'd3, 8'h77, 1'b0, 1'b0);
    bus_wr(2'd3, 8'h55, 1'b1, 1'b1);
    bus_wr(2'd2, 8'hEE, 1'b0, 1'b1);
    bus_rd(2'd3, r); chk("R2 control kept", r, 8'h1F);
    bus_rd(2'd2, r); chk("R2 command kept", r, 8'h0B);
    prev = r;
    bus_rd(2'd1, r, 1'b0, 1'b0); chk("R2 rdata held", r, prev);

    // R3 R5 R8 at 0x1F: divisor 6, 8N1, both directions
    bc = bit_cyc(6);
    bus_wr(2'd0, 8'h5A);
    fork
      check_tx("R3 R5 div6", 8'h5A, 8, bc);
      send_rx(8'hA3, 8, bc, 1'b1);
    join
    repeat (8) @(negedge clk);
    bus_rd(2'd1, r); chk("R8 full flag", r, 8'h18);
    bus_rd(2'd0, r); chk("R8 data", r, 8'hA3);
    bus_rd(2'd1, r); chk("R8 flag cleared", r, 8'h10);
    repeat (bc) @(negedge clk);

    // R5 further rate selections
    bus_wr(2'd3, 8'h1E);
    bus_wr(2'd0, 8'hC3);
    check_tx("R5 div12", 8'hC3, 8, bit_cyc(12));
    repeat (bit_cyc(12)) @(negedge clk);
    bus_wr(2'd3, 8'h1D);
    bus_wr(2'd0, 8'h96);
    check_tx("R5 div16", 8'h96, 8, bit_cyc(16));
    repeat (bit_cyc(16)) @(negedge clk);
    bus_wr(2'd3, 8'h0F);
    bus_wr(2'd0, 8'h3C);
    check_tx("R5 rate field ignored when bit4 clear", 8'h3C, 8, bit_cyc(1));
    repeat (bit_cyc(1)) @(negedge clk);

    // R3 R8 sweep at the fastest rate
    bus_wr(2'd3, 8'h00);
    bc = bit_cyc(1);
    for (int i = 0; i < 64; i++) begin
      v = 8'(i * 37 + 11);
      bus_wr(2'd0, v);
      fork
        check_tx("R3 sweep", v, 8, bc);
        send_rx(~v, 8, bc, 1'b1);
      join
      repeat (8) @(negedge clk);
      bus_rd(2'd1, r); chk("R8 sweep status", r, 8'h18);
      bus_rd(2'd0, r); chk("R8 sweep data", r, ~v);
    end
    repeat (bc) @(negedge clk);

    // R6 word lengths
    for (int k = 1; k < 4; k++) begin
      bus_wr(2'd3, 8'(k << 5));
      bus_wr(2'd0, 8'hB5);
      fork
        check_tx("R6 tx length", 8'hB5, 8 - k, bc);
        send_rx(8'h6E, 8 - k, bc, 1'b1);
      join
      repeat (8) @(negedge clk);
      bus_rd(2'd0, r); chk("R6 rx length", r, 8'h6E & 8'((1 << (8 - k)) - 1));
      repeat (bc) @(negedge clk);
    end

    // R7 two stop bits, R4 transmit-empty flag
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd0, 8'hFF);
    bus_rd(2'd1, r); chk("R4 empty low while queued", r & 8'h10, 8'h00);
    while (txd !== 1'b0) @(negedge clk);
    repeat (10 * bc + bc / 2) @(negedge clk);
    chk("R7 second stop bit high", {7'b0, txd}, 8'h01);
    repeat (bc) @(negedge clk);
    chk("R7 next start after two stops", {7'b0, txd}, 8'h00);
    repeat (12 * bc) @(negedge clk);
    bus_rd(2'd1, r); chk("R4 empty after send", r, 8'h10);

    // R9 short low pulse on the receive line
    bus_wr(2'd3, 8'h00);
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * bc) @(negedge clk);
    bus_rd(2'd1, r); chk("R9 glitch rejected", r, 8'h10);

    // R10 framing error
    send_rx(8'h81, 8, bc, 1'b0);
    repeat (8) @(negedge clk);
    bus_rd(2'd1, r); chk("R10 framing flag", r, 8'h1A);
    bus_rd(2'd0, r); chk("R10 byte delivered", r, 8'h81);
    bus_rd(2'd1, r); chk("R10 cleared by read", r, 8'h10);

    // R11 overrun
    send_rx(8'h11, 8, bc, 1'b1);
    send_rx(8'h22, 8, bc, 1'b1);
    repeat (8) @(negedge clk);
    bus_rd(2'd1, r); chk("R11 overrun flag", r, 8'h1C);
    bus_rd(2'd0, r); chk("R11 first byte kept", r, 8'h11);
    bus_rd(2'd1, r); chk("R11 cleared by read", r, 8'h10);

    // R12 soft reset through the status offset
    send_rx(8'h44, 8, bc, 1'b0);
    repeat (8) @(negedge clk);
    bus_wr(2'd2, 8'h0B);
    bus_wr(2'd3, 8'h9F);
    bus_wr(2'd1, 8'hA5);
    bus_rd(2'd1, r); chk("R12 status", r, 8'h10);
    bus_rd(2'd2, r); chk("R12 command", r, 8'h00);
    bus_rd(2'd3, r); chk("R12 control", r, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule